// File: doc/BRIEF.md
# Time-Slot Interchange Output Path

This block is the transmit half of a 128-slot non-blocking time-slot interchange. Four serial output streams each carry 32 eight-bit channels per frame, and each bit cell lasts two clocks, so a frame is 512 clocks long. For every output slot the block reads a low connection word and a high connection entry. The entry selects one of two sources for the slot. In switched mode the low word is an address into the data memory, which holds the last byte received on every input channel. In message mode the low word is itself the byte sent. The entry also gives each slot its own output enable.

The three memories stay outside the block and are read through synchronous ports with one cycle of latency. The block reads them one channel ahead of transmission and loads four shift registers at each channel boundary. Each serial output is a data bit paired with an enable bit, which stands in for a three-state pin. A global enable input silences every stream. A global override input puts every slot into message mode and turns its output on.

Top module: `tsi_out_path`

## Requirements
- R1: The frame position runs from 0 to 511 and wraps. A high `frame_sync_i` in any cycle sets the position of the next cycle to 0. Channel n occupies positions 16n to 16n+15.
- R2: Within a channel, bit 7 goes out first. Bit 7-j is presented during positions 2j and 2j+1 of the channel. Output bits change only on the clock edge that begins a two-clock cell.
- R3: During the first half of channel n, the block reads the connection memories for channel n+1 (mod 32) on every stream, in stream order. At step s (1 to 4), `cm_addr_o` equals (s-1)*32 + (n+1). At step s (3 to 6), `dm_addr_o` equals bits 6:0 of the low word fetched for stream s-3.
- R4: A slot is in switched mode when bit 2 of its high entry is 0 and the override is low. It then sends the data-memory byte at address low[6:0], where low[6:5] is the input stream and low[4:0] the input channel. Bit 7 of the low word has no effect.
- R5: A slot is in message mode when bit 2 of its high entry is 1. It then sends its low word unchanged, and the same byte goes out again every frame while the memory holds it.
- R6: Bit 0 of the high entry enables a slot. A disabled slot drives enable 0 and data 0. Bit 1 of the entry has no effect.
- R7: Each output enable is the slot enable ANDed with `out_enable_i` as sampled on the previous clock edge. When the input is low, all four streams drive enable 0 and data 0 from the next cycle on, whatever the entries say.
- R8: While `msg_all_i` is high, every slot behaves as if bits 2 and 0 of its high entry were both 1.
- R9: While reset is asserted, and after it until the first channel load, all outputs are 0 and the position is 0. Channel 0 of the first frame after reset is disabled.
- R10: Memory contents and `msg_all_i` are sampled only during steps 0 to 7 of the channel before the slot. A change made during steps 8 to 15 takes effect from the following channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync_i | input | 1 | Forces frame position 0 on the next cycle |
| out_enable_i | input | 1 | Global output enable; low silences all streams |
| msg_all_i | input | 1 | Global override: every slot in message mode and enabled |
| cm_addr_o | output | 7 | Connection-memory read address {stream, channel} |
| cml_rdata_i | input | 8 | Low connection word, one cycle after address |
| cmh_rdata_i | input | 3 | High connection entry (bit 2 message, bit 0 enable) |
| dm_addr_o | output | 7 | Data-memory read address {input stream, channel} |
| dm_rdata_i | input | 8 | Data-memory byte, one cycle after address |
| ser_data_o | output | 4 | Serial data bit per output stream |
| ser_en_o | output | 4 | Driver enable per output stream |

## Verification
The results fall due at three different latencies. A serial bit of channel n appears 16n clocks after frame position zero and holds for two clocks. A change on the global enable reaches the outputs one clock later. A change to memory or to the override reaches the outputs only at the next channel boundary, because everything is read one channel ahead. The reference model advances its frame position on each rising edge. It takes the expected bytes for channel n+1 at step 0 of channel n and moves them to the output at step 15. It records the enable input on each rising edge. Outputs are compared on every falling edge. Stimulus that changes memory or the override is applied only at step 10, where no fetch is in progress. The model leaves unchecked the partial channel that follows a mid-frame resync.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int TSI_STREAMS  = 4;
  localparam int TSI_CHANNELS = 32;
  localparam int TSI_WORD_W   = 8;
  localparam int CMH_W        = 3;
  localparam int CMH_MSG_BIT  = 2;
  localparam int CMH_EN_BIT   = 0;
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer import tsi_pkg::*; #(
  parameter int CHANNELS = TSI_CHANNELS,
  parameter int WORD_W   = TSI_WORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_sync_i,
  output logic [$clog2(CHANNELS)-1:0] chan_o,
  output logic [$clog2(WORD_W):0]     step_o
);
  localparam int CH_W   = $clog2(CHANNELS);
  localparam int STEP_W = $clog2(WORD_W) + 1;
  localparam int CNT_W  = CH_W + STEP_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || frame_sync_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign chan_o = cnt_q[CNT_W-1:STEP_W];
  assign step_o = cnt_q[STEP_W-1:0];

  // R1: a sync pulse realigns the frame on the following cycle
  a_r1_resync: assert property (@(posedge clk) disable iff (rst)
    frame_sync_i |=> (chan_o == '0 && step_o == '0));
endmodule

// File: rtl/tsi_fetch_seq.sv
module tsi_fetch_seq import tsi_pkg::*; #(
  parameter int STREAMS  = TSI_STREAMS,
  parameter int CHANNELS = TSI_CHANNELS,
  parameter int WORD_W   = TSI_WORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic [$clog2(CHANNELS)-1:0] chan_i,
  input  logic [$clog2(WORD_W):0]     step_i,
  input  logic msg_all_i,
  output logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0] cm_addr_o,
  input  logic [WORD_W-1:0] cml_rdata_i,
  input  logic [CMH_W-1:0]  cmh_rdata_i,
  output logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0] dm_addr_o,
  input  logic [WORD_W-1:0] dm_rdata_i,
  output logic [STREAMS-1:0][WORD_W-1:0] slot_byte_o,
  output logic [STREAMS-1:0] slot_en_o
);
  localparam int ST_W     = $clog2(STREAMS);
  localparam int CH_W     = $clog2(CHANNELS);
  localparam int ADDR_W   = ST_W + CH_W;
  localparam int STEP_W   = $clog2(WORD_W) + 1;
  localparam int CM_CAP0  = 2;   // first step with connection data back
  localparam int DM_CAP0  = 4;   // first step with data-memory byte back

  logic [CH_W-1:0]   ahead_chan;
  logic [ADDR_W-1:0] cm_addr_q;
  logic [ADDR_W-1:0] dm_addr_q;
  logic              unused_cmh;

  assign ahead_chan = chan_i + CH_W'(1);
  assign unused_cmh = ^cmh_rdata_i;

  // Issue one connection read per stream during steps 0..STREAMS-1
  always_ff @(posedge clk) begin
    if (rst) cm_addr_q <= '0;
    else if (step_i < STEP_W'(STREAMS))
      cm_addr_q <= {step_i[ST_W-1:0], ahead_chan};
  end

  // Forward each low word as a data-memory address as it returns
  always_ff @(posedge clk) begin
    if (rst) dm_addr_q <= '0;
    else if (step_i >= STEP_W'(CM_CAP0) && step_i < STEP_W'(CM_CAP0 + STREAMS))
      dm_addr_q <= cml_rdata_i[ADDR_W-1:0];
  end

  assign cm_addr_o = cm_addr_q;
  assign dm_addr_o = dm_addr_q;

  for (genvar g = 0; g < STREAMS; g++) begin : g_slot
    logic [WORD_W-1:0] low_q;
    logic              msg_q;
    logic              en_q;
    logic [WORD_W-1:0] byte_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        low_q  <= '0;
        msg_q  <= 1'b0;
        en_q   <= 1'b0;
        byte_q <= '0;
      end else begin
        if (step_i == STEP_W'(CM_CAP0 + g)) begin
          low_q <= cml_rdata_i;
          msg_q <= cmh_rdata_i[CMH_MSG_BIT] | msg_all_i;
          en_q  <= cmh_rdata_i[CMH_EN_BIT]  | msg_all_i;
        end
        if (step_i == STEP_W'(DM_CAP0 + g))
          byte_q <= msg_q ? low_q : dm_rdata_i;
      end
    end

    assign slot_byte_o[g] = byte_q;
    assign slot_en_o[g]   = en_q;

    // R8: override forces the captured slot on
    a_r8_override_on: assert property (@(posedge clk) disable iff (rst)
      (msg_all_i && step_i == STEP_W'(CM_CAP0 + g)) |=> (en_q && msg_q));
  end

  // R3: address presented in steps 1..STREAMS names the next channel
  a_r3_fetch_ahead: assert property (@(posedge clk) disable iff (rst)
    (step_i >= STEP_W'(1) && step_i <= STEP_W'(STREAMS))
      |-> (cm_addr_o[CH_W-1:0] == ahead_chan));
endmodule

// File: rtl/tsi_serializer.sv
module tsi_serializer import tsi_pkg::*; #(
  parameter int WORD_W = TSI_WORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic [$clog2(WORD_W):0] step_i,
  input  logic [WORD_W-1:0] load_byte_i,
  input  logic load_en_i,
  input  logic oe_i,
  output logic ser_d_o,
  output logic ser_en_o
);
  localparam int STEP_W    = $clog2(WORD_W) + 1;
  localparam int LAST_STEP = 2 * WORD_W - 1;

  logic [WORD_W-1:0] shreg_q, shreg_nxt;
  logic              slot_en_q, slot_en_nxt;
  logic              out_d_q, out_en_q;

  always_comb begin
    shreg_nxt   = shreg_q;
    slot_en_nxt = slot_en_q;
    if (step_i == STEP_W'(LAST_STEP)) begin
      shreg_nxt   = load_byte_i;
      slot_en_nxt = load_en_i;
    end else if (step_i[0]) begin
      shreg_nxt = {shreg_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q   <= '0;
      slot_en_q <= 1'b0;
      out_d_q   <= 1'b0;
      out_en_q  <= 1'b0;
    end else begin
      shreg_q   <= shreg_nxt;
      slot_en_q <= slot_en_nxt;
      out_en_q  <= slot_en_nxt & oe_i;
      out_d_q   <= slot_en_nxt & oe_i & shreg_nxt[WORD_W-1];
    end
  end

  assign ser_d_o  = out_d_q;
  assign ser_en_o = out_en_q;

  // R2: the shifter holds through the first clock of every bit cell
  a_r2_cell_hold: assert property (@(posedge clk) disable iff (rst)
    (step_i[0] == 1'b0) |=> $stable(shreg_q));
  // R7: global enable low silences the driver on the next cycle
  a_r7_oe_quiet: assert property (@(posedge clk) disable iff (rst)
    !oe_i |=> !ser_en_o);
  // R6: an undriven output carries a zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !ser_en_o |-> !ser_d_o);
endmodule

// File: rtl/tsi_out_path.sv
module tsi_out_path import tsi_pkg::*; #(
  parameter int STREAMS  = TSI_STREAMS,
  parameter int CHANNELS = TSI_CHANNELS,
  parameter int WORD_W   = TSI_WORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_sync_i,
  input  logic out_enable_i,
  input  logic msg_all_i,
  output logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0] cm_addr_o,
  input  logic [WORD_W-1:0] cml_rdata_i,
  input  logic [CMH_W-1:0]  cmh_rdata_i,
  output logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0] dm_addr_o,
  input  logic [WORD_W-1:0] dm_rdata_i,
  output logic [STREAMS-1:0] ser_data_o,
  output logic [STREAMS-1:0] ser_en_o
);
  localparam int CH_W   = $clog2(CHANNELS);
  localparam int STEP_W = $clog2(WORD_W) + 1;

  logic [CH_W-1:0]   chan;
  logic [STEP_W-1:0] step;
  logic [STREAMS-1:0][WORD_W-1:0] slot_byte;
  logic [STREAMS-1:0] slot_en;

  tsi_frame_timer #(.CHANNELS(CHANNELS), .WORD_W(WORD_W)) i_timer (
    .clk          (clk),
    .rst          (rst),
    .frame_sync_i (frame_sync_i),
    .chan_o       (chan),
    .step_o       (step)
  );

  tsi_fetch_seq #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .WORD_W(WORD_W)) i_fetch (
    .clk         (clk),
    .rst         (rst),
    .chan_i      (chan),
    .step_i      (step),
    .msg_all_i   (msg_all_i),
    .cm_addr_o   (cm_addr_o),
    .cml_rdata_i (cml_rdata_i),
    .cmh_rdata_i (cmh_rdata_i),
    .dm_addr_o   (dm_addr_o),
    .dm_rdata_i  (dm_rdata_i),
    .slot_byte_o (slot_byte),
    .slot_en_o   (slot_en)
  );

  for (genvar s = 0; s < STREAMS; s++) begin : g_stream
    tsi_serializer #(.WORD_W(WORD_W)) i_ser (
      .clk         (clk),
      .rst         (rst),
      .step_i      (step),
      .load_byte_i (slot_byte[s]),
      .load_en_i   (slot_en[s]),
      .oe_i        (out_enable_i),
      .ser_d_o     (ser_data_o[s]),
      .ser_en_o    (ser_en_o[s])
    );
  end

  // R9: reset leaves every stream silent
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (ser_en_o == '0 && ser_data_o == '0));
endmodule

// File: tb/test_tsi_out_path.sv
module test_tsi_out_path;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NC = 32;
  localparam int FRAME = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs = 1'b0;
  logic oe = 1'b0;
  logic msg_all = 1'b0;
  logic [6:0] cm_addr, dm_addr;
  logic [7:0] cml_rd, dm_rd;
  logic [2:0] cmh_rd;
  logic [3:0] ser_data, ser_en;

  logic [7:0] cml_mem [128];
  logic [2:0] cmh_mem [128];
  logic [7:0] dm_mem  [128];

  int checks = 0, errors = 0;
  bit done = 0;
  bit started = 0;
  bit mid_fs_arm = 0;

  // reference model state
  int   pos = 0;
  int   st = 0;          // 0 known silent, 1 valid, 2 unknown after resync
  bit   oe_prev = 0;
  logic [7:0] pend_byte [NS];
  bit         pend_en   [NS];
  string      pend_tag  [NS];
  logic [7:0] cur_byte  [NS];
  bit         cur_en    [NS];
  string      cur_tag   [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsi_out_path i_tsi_out_path (
    .clk          (clk),
    .rst          (rst),
    .frame_sync_i (fs),
    .out_enable_i (oe),
    .msg_all_i    (msg_all),
    .cm_addr_o    (cm_addr),
    .cml_rdata_i  (cml_rd),
    .cmh_rdata_i  (cmh_rd),
    .dm_addr_o    (dm_addr),
    .dm_rdata_i   (dm_rd),
    .ser_data_o   (ser_data),
    .ser_en_o     (ser_en)
  );

  // synchronous memories outside the block
  always @(posedge clk) begin
    cml_rd <= cml_mem[cm_addr];
    cmh_rd <= cmh_mem[cm_addr];
    dm_rd  <= dm_mem[dm_addr];
  end

  // R1: frame sync at position 511, plus one armed mid-frame pulse
  always @(negedge clk) begin
    if (!rst && mid_fs_arm && pos == 200) begin
      fs = 1'b1;
      mid_fs_arm = 0;
    end else begin
      fs = !rst && (pos == FRAME - 1);
    end
  end

  // Behavioural reference: R1 R4 R5 R6 R8 R9 R10
  always @(posedge clk) begin : model
    int step, ch, idx;
    logic [2:0] h;
    logic [7:0] l;
    bit msg;
    if (rst) begin
      pos = 0;
      st = 0;
      oe_prev = 0;
    end else begin
      step = pos % 16;
      ch = pos / 16;
      if (step == 0) begin
        for (int k = 0; k < NS; k++) begin
          idx = k * NC + (ch + 1) % NC;
          h = cmh_mem[idx];
          l = cml_mem[idx];
          msg = h[2] || msg_all;
          pend_en[k]   = h[0] || msg_all;
          pend_byte[k] = msg ? l : dm_mem[l[6:0]];
          pend_tag[k]  = msg_all ? "R8" : (!h[0] ? "R6" : (h[2] ? "R5" : "R4"));
        end
      end
      if (step == 15) begin
        for (int k = 0; k < NS; k++) begin
          cur_byte[k] = pend_byte[k];
          cur_en[k]   = pend_en[k];
          cur_tag[k]  = pend_tag[k];
        end
        st = 1;
      end
      if (fs && pos != FRAME - 1) st = 2;
      oe_prev = oe;
      pos = fs ? 0 : (pos + 1) % FRAME;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin : compare
    int step, ch, b, exp_a;
    bit exp_en, exp_d;
    string tag;
    if (started && !done) begin
      step = pos % 16;
      ch = pos / 16;
      b = 7 - step / 2;   // R2: MSB first, two clocks per bit
      if (st != 2) begin
        for (int k = 0; k < NS; k++) begin
          exp_en = (st == 1) && cur_en[k] && oe_prev;
          exp_d  = exp_en && cur_byte[k][b];
          tag = (st == 0) ? "R9" : (!oe_prev ? "R7" : cur_tag[k]);
          checks++;
          if (ser_en[k] !== exp_en || ser_data[k] !== exp_d) begin
            errors++;
            if (errors < 20)
              $display("FAIL %s (R2 bit %0d) stream %0d pos %0d: en=%b data=%b expected en=%b data=%b",
                       tag, b, k, pos, ser_en[k], ser_data[k], exp_en, exp_d);
          end
        end
      end
      // R3: read addresses run one channel ahead
      if (step >= 1 && step <= 4) begin
        exp_a = (step - 1) * NC + (ch + 1) % NC;
        checks++;
        if (int'(cm_addr) != exp_a) begin
          errors++;
          if (errors < 20)
            $display("FAIL R3 cm_addr pos %0d: got %0d expected %0d", pos, cm_addr, exp_a);
        end
      end
      if (step >= 3 && step <= 6) begin
        exp_a = int'(cml_mem[(step - 3) * NC + (ch + 1) % NC][6:0]);
        checks++;
        if (int'(dm_addr) != exp_a) begin
          errors++;
          if (errors < 20)
            $display("FAIL R3 dm_addr pos %0d: got %0d expected %0d", pos, dm_addr, exp_a);
        end
      end
    end
  end

  task automatic wait_step(input int s);
    do @(negedge clk); while (pos % 16 != s);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill_random();
    for (int i = 0; i < 128; i++) begin
      cmh_mem[i] = 3'($urandom);
      cml_mem[i] = 8'($urandom);
      dm_mem[i]  = 8'($urandom);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      cmh_mem[i] = '0;
      cml_mem[i] = '0;
      dm_mem[i]  = '0;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (ser_en !== 4'b0 || ser_data !== 4'b0) begin
      errors++;
      $display("FAIL R9 reset outputs: en=%b data=%b expected en=0000 data=0000", ser_en, ser_data);
    end
    rst = 1'b0;
    oe = 1'b1;
    started = 1;
    // R6: all entries zero, everything disabled
    run(2 * FRAME);
    // R4 R5 R6 random connections, message bytes repeat each frame (R10 at step 10)
    wait_step(10);
    fill_random();
    run(3 * FRAME);
    // R7: global enable toggled at arbitrary points
    for (int r = 0; r < 6; r++) begin
      oe = 1'b0;
      run(37 + r * 11);
      oe = 1'b1;
      run(53);
    end
    // R8: global override for one frame
    wait_step(10);
    msg_all = 1'b1;
    run(FRAME + 40);
    wait_step(10);
    msg_all = 1'b0;
    run(FRAME);
    // R5 R6: bit 2 and bit 0 set everywhere, then bit 1 alone
    wait_step(10);
    for (int i = 0; i < 128; i++) cmh_mem[i] = 3'b111;
    run(FRAME);
    wait_step(10);
    for (int i = 0; i < 128; i++) cmh_mem[i] = 3'b010;
    run(FRAME);
    // R4: switched everywhere with bit 7 of the low word set
    wait_step(10);
    for (int i = 0; i < 128; i++) begin
      cmh_mem[i] = 3'b001;
      cml_mem[i] = 8'h80 | 8'((i * 37 + 5) % 128);
      dm_mem[i]  = 8'($urandom);
    end
    run(FRAME);
    // R1: mid-frame resync
    wait_step(10);
    fill_random();
    @(posedge clk);
    mid_fs_arm = 1;
    run(3 * FRAME);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule